// File: doc/BRIEF.md
# Interleaved MSI Vector Aggregator

This block collects message-signalled interrupts that arrive as writes to one doorbell register and spreads them over a set of interrupt banks. The data word of each doorbell write is a vector number. The vector is recorded as a pending bit in the status register of its bank. Vectors are interleaved: vector `v` belongs to bank `v mod 8` and sits at bit `v >> 3` of that bank. Each bank therefore gathers vectors that are eight apart, and drives one interrupt line of its own.

Software works through a separate CPU register port. Through this port it unmasks vectors with an enable-set register, masks them with an enable-clear register, clears pending bits by writing ones to the status register, and acknowledges a bank through a shared end-of-interrupt register. Each bank's line behaves as an edge.

- A bank that is armed and has any pending, enabled vector raises its line for one clock.
- The bank then disarms.
- The acknowledge code for bank `g` (the value `g + 4`) re-arms the bank. If vectors are still pending and enabled, the bank fires again.

Inbound MSI writes use their own write port, so a doorbell hit and a software status clear can land in the same clock.

Top module: `msi_vector_aggregator`

## Requirements
- R1: After reset, every status bit and every enable bit is 0, every bank is armed, and all interrupt lines are low.
- R2: An MSI-port write to offset 0x054 with data `v` < 32 sets bit `v >> 3` of the status of bank `v mod 8`. Bank `g` status reads at offset 0x104 + 16*g, with its bits in [3:0] and 0 above.
- R3: MSI-port writes with data of 32 or more, or to any offset other than 0x054, change no status bit.
- R4: A status bit latches while its vector is masked, and a masked pending bit does not raise the line.
- R5: On the CPU port, writing ones to offset 0x108 + 16*g sets enable bits of bank `g`. Writing ones to 0x10C + 16*g clears them. Reading either offset returns the bank's current enable mask in [3:0].
- R6: Writing ones to a bank's status offset on the CPU port clears those status bits and leaves the others.
- R7: The line of bank `g` is high for exactly one clock when the bank is armed and has a pending, enabled bit. It rises right after the clock edge that completes that condition. The bank then disarms.
- R8: A CPU write of value `g + 4` to offset 0x050 re-arms bank `g` only; values 0 to 3 and 12 or more re-arm nothing. A re-armed bank with pending, enabled bits fires again at once.
- R9: When a doorbell set and a status clear hit the same bit in the same clock, the bit ends set. A clear of a different bit in that clock still takes effect.
- R10: Unmasking a vector that is already pending in an armed bank raises the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_wr_i | input | 1 | Inbound MSI write strobe |
| msi_addr_i | input | 12 | Inbound MSI write offset |
| msi_data_i | input | 32 | Inbound MSI data (vector number) |
| cpu_wr_i | input | 1 | CPU register write strobe |
| cpu_addr_i | input | 12 | CPU write offset |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_rd_addr_i | input | 12 | CPU read offset |
| cpu_rdata_o | output | 32 | CPU read data (combinational) |
| irq_o | output | 8 | One interrupt line per bank |

## Verification
The hardest case to reach from the ports is the collision. A doorbell set and a write-one-to-clear must land on the same status bit in the same clock. Only one of the two ports carries each of them, so the stimulus drives both ports in the same cycle: once with the same bit, once with neighbouring bits in one bank, and once with the clear alone as a control. The arm/disarm cycle is also delicate. The bench counts the exact clock in which each line rises and falls, around unmasking, acknowledging, clearing and re-firing. It also shows that reserved acknowledge codes leave a bank silent.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned OFS_DOORBELL   = 32'h054;
  localparam int unsigned OFS_ACK        = 32'h050;
  localparam int unsigned OFS_BANK_BASE  = 32'h104;
  localparam int unsigned BANK_STRIDE    = 16;
  localparam int unsigned DELTA_STATUS   = 0;
  localparam int unsigned DELTA_EN_SET   = 4;
  localparam int unsigned DELTA_EN_CLR   = 8;
  localparam int unsigned ACK_BANK_CODE0 = 4;

  // vector number that lives in bank g at bit b
  function automatic int unsigned vector_of(int unsigned g, int unsigned b,
                                            int unsigned nbanks);
    return b * nbanks + g;
  endfunction

  // register offset of one of the three per-bank registers
  function automatic int unsigned bank_reg(int unsigned g, int unsigned delta);
    return OFS_BANK_BASE + g * BANK_STRIDE + delta;
  endfunction

  // acknowledge code that re-arms bank g
  function automatic int unsigned ack_code(int unsigned g);
    return g + ACK_BANK_CODE0;
  endfunction
endpackage

// File: rtl/msi_agg_doorbell.sv
module msi_agg_doorbell
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 8,
  parameter int unsigned BITS_PER_BANK = 4,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 32
) (
  input  logic                                      msi_wr_i,
  input  logic [ADDR_W-1:0]                         msi_addr_i,
  input  logic [DATA_W-1:0]                         msi_data_i,
  output logic [NUM_BANKS-1:0][BITS_PER_BANK-1:0]   set_o
);
  localparam int unsigned NUM_VEC = NUM_BANKS * BITS_PER_BANK;

  logic door_hit;
  assign door_hit = msi_wr_i && (msi_addr_i == ADDR_W'(OFS_DOORBELL));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    for (genvar b = 0; b < BITS_PER_BANK; b++) begin : g_bit
      assign set_o[g][b] = door_hit &&
                           (msi_data_i == DATA_W'(vector_of(g, b, NUM_BANKS)));
    end
  end

  always_comb begin
    AST_ONE_VECTOR_PER_WRITE: assert ($onehot0(set_o)) else $error("doorbell set more than one bit"); // R2
    AST_OUT_OF_RANGE_DROPPED: assert (!(door_hit && msi_data_i >= DATA_W'(NUM_VEC)) || set_o == '0)
      else $error("out of range vector set a bit"); // R3
  end
endmodule

// File: rtl/msi_agg_regdec.sv
module msi_agg_regdec
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 8,
  parameter int unsigned BITS_PER_BANK = 4,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 32
) (
  input  logic                                      cpu_wr_i,
  input  logic [ADDR_W-1:0]                         cpu_addr_i,
  input  logic [DATA_W-1:0]                         cpu_wdata_i,
  output logic [NUM_BANKS-1:0][BITS_PER_BANK-1:0]   sts_clr_o,
  output logic [NUM_BANKS-1:0][BITS_PER_BANK-1:0]   en_set_o,
  output logic [NUM_BANKS-1:0][BITS_PER_BANK-1:0]   en_clr_o,
  output logic [NUM_BANKS-1:0]                      ack_o
);
  logic ack_hit;
  assign ack_hit = cpu_wr_i && (cpu_addr_i == ADDR_W'(OFS_ACK));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit_sts, hit_set, hit_clr;
    assign hit_sts = cpu_wr_i && (cpu_addr_i == ADDR_W'(bank_reg(g, DELTA_STATUS)));
    assign hit_set = cpu_wr_i && (cpu_addr_i == ADDR_W'(bank_reg(g, DELTA_EN_SET)));
    assign hit_clr = cpu_wr_i && (cpu_addr_i == ADDR_W'(bank_reg(g, DELTA_EN_CLR)));
    assign sts_clr_o[g] = hit_sts ? cpu_wdata_i[BITS_PER_BANK-1:0] : '0;
    assign en_set_o[g]  = hit_set ? cpu_wdata_i[BITS_PER_BANK-1:0] : '0;
    assign en_clr_o[g]  = hit_clr ? cpu_wdata_i[BITS_PER_BANK-1:0] : '0;
    assign ack_o[g]     = ack_hit && (cpu_wdata_i == DATA_W'(ack_code(g)));
  end

  always_comb begin
    AST_ACK_SINGLE_BANK: assert ($onehot0(ack_o)) else $error("ack hit several banks"); // R8
  end
endmodule

// File: rtl/msi_agg_bank.sv
module msi_agg_bank #(
  parameter int unsigned BITS_PER_BANK = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BITS_PER_BANK-1:0] set_i,
  input  logic [BITS_PER_BANK-1:0] sts_clr_i,
  input  logic [BITS_PER_BANK-1:0] en_set_i,
  input  logic [BITS_PER_BANK-1:0] en_clr_i,
  input  logic                     ack_i,
  output logic [BITS_PER_BANK-1:0] status_o,
  output logic [BITS_PER_BANK-1:0] enable_o,
  output logic                     irq_o
);
  logic [BITS_PER_BANK-1:0] status_q, enable_q;
  logic                     armed_q;
  logic                     live_pending;

  assign live_pending = |(status_q & enable_q);
  assign irq_o        = armed_q && live_pending;
  assign status_o     = status_q;
  assign enable_o     = enable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      armed_q  <= 1'b1;
    end else begin
      status_q <= (status_q & ~sts_clr_i) | set_i;
      enable_q <= (enable_q & ~en_clr_i) | en_set_i;
      if (ack_i)      armed_q <= 1'b1;
      else if (irq_o) armed_q <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i))); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_clr_i & ~set_i)) |=> ((status_q & $past(sts_clr_i & ~set_i)) == '0)); // R6
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set_i) |=> ((enable_q & $past(en_set_i)) == $past(en_set_i))); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> !irq_o); // R7
  AST_ACK_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> armed_q); // R8
endmodule

// File: rtl/msi_vector_aggregator.sv
module msi_vector_aggregator
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 8,
  parameter int unsigned BITS_PER_BANK = 4,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msi_wr_i,
  input  logic [ADDR_W-1:0]    msi_addr_i,
  input  logic [DATA_W-1:0]    msi_data_i,
  input  logic                 cpu_wr_i,
  input  logic [ADDR_W-1:0]    cpu_addr_i,
  input  logic [DATA_W-1:0]    cpu_wdata_i,
  input  logic [ADDR_W-1:0]    cpu_rd_addr_i,
  output logic [DATA_W-1:0]    cpu_rdata_o,
  output logic [NUM_BANKS-1:0] irq_o
);
  logic [NUM_BANKS-1:0][BITS_PER_BANK-1:0] door_set, sts_clr, en_set, en_clr;
  logic [NUM_BANKS-1:0][BITS_PER_BANK-1:0] status, enable;
  logic [NUM_BANKS-1:0]                    ack;

  msi_agg_doorbell #(
    .NUM_BANKS(NUM_BANKS), .BITS_PER_BANK(BITS_PER_BANK),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_doorbell (
    .msi_wr_i   (msi_wr_i),
    .msi_addr_i (msi_addr_i),
    .msi_data_i (msi_data_i),
    .set_o      (door_set)
  );

  msi_agg_regdec #(
    .NUM_BANKS(NUM_BANKS), .BITS_PER_BANK(BITS_PER_BANK),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regdec (
    .cpu_wr_i    (cpu_wr_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .sts_clr_o   (sts_clr),
    .en_set_o    (en_set),
    .en_clr_o    (en_clr),
    .ack_o       (ack)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    msi_agg_bank #(.BITS_PER_BANK(BITS_PER_BANK)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (door_set[g]),
      .sts_clr_i (sts_clr[g]),
      .en_set_i  (en_set[g]),
      .en_clr_i  (en_clr[g]),
      .ack_i     (ack[g]),
      .status_o  (status[g]),
      .enable_o  (enable[g]),
      .irq_o     (irq_o[g])
    );
  end

  always_comb begin
    cpu_rdata_o = '0;
    for (int g = 0; g < int'(NUM_BANKS); g++) begin
      if (cpu_rd_addr_i == ADDR_W'(bank_reg(g, DELTA_STATUS)))
        cpu_rdata_o = DATA_W'(status[g]);
      if (cpu_rd_addr_i == ADDR_W'(bank_reg(g, DELTA_EN_SET)) ||
          cpu_rd_addr_i == ADDR_W'(bank_reg(g, DELTA_EN_CLR)))
        cpu_rdata_o = DATA_W'(enable[g]);
    end
  end

  AST_LINES_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0)); // R1
endmodule

// File: tb/msi_vector_aggregator_tb.sv
module msi_vector_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_wr = 1'b0;
  logic [11:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        cpu_wr = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [11:0] cpu_rd_addr = '0;
  logic [31:0] cpu_rdata;
  logic [7:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msi_vector_aggregator u_dut (
    .clk(clk), .rst_n(rst_n),
    .msi_wr_i(msi_wr), .msi_addr_i(msi_addr), .msi_data_i(msi_data),
    .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rd_addr_i(cpu_rd_addr), .cpu_rdata_o(cpu_rdata), .irq_o(irq)
  );

  // offsets computed from the requirement text
  function automatic logic [11:0] sts_ofs(int g); return 12'(32'h104 + 16 * g); endfunction
  function automatic logic [11:0] set_ofs(int g); return 12'(32'h108 + 16 * g); endfunction
  function automatic logic [11:0] clr_ofs(int g); return 12'(32'h10C + 16 * g); endfunction
  function automatic int vbank(int v); return v % 8; endfunction
  function automatic logic [31:0] vmask(int v); return 32'(1) << (v / 8); endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic cpu_write(input logic [11:0] a, input logic [31:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic msi_write(input logic [11:0] a, input logic [31:0] d);
    msi_wr = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_wr = 1'b0;
  endtask

  task automatic both_write(input logic [31:0] vec, input logic [11:0] a,
                            input logic [31:0] d);
    msi_wr = 1'b1; msi_addr = 12'h054; msi_data = vec;
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    msi_wr = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [11:0] a, output logic [31:0] d);
    cpu_rd_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1", "irq after reset", 32'(irq), 32'h0);
    read_reg(sts_ofs(0), d); check("R1", "bank0 status", d, 0);
    read_reg(sts_ofs(7), d); check("R1", "bank7 status", d, 0);
    read_reg(set_ofs(3), d); check("R1", "bank3 enable", d, 0);
  endtask

  task automatic t_masked_latch;
    logic [31:0] d;
    msi_write(12'h054, 13);
    check("R4", "masked vector raises nothing", 32'(irq), 0);
    read_reg(sts_ofs(vbank(13)), d); check("R2", "vector 13 status", d, vmask(13));
    msi_write(12'h054, 0);
    read_reg(sts_ofs(0), d); check("R2", "vector 0 status", d, 32'h1);
    msi_write(12'h054, 31);
    read_reg(sts_ofs(7), d); check("R2", "vector 31 status", d, 32'h8);
    check("R4", "still quiet", 32'(irq), 0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    msi_write(12'h054, 32);
    msi_write(12'h054, 40);
    msi_write(12'h058, 2);
    msi_write(12'h050, 2);
    read_reg(sts_ofs(0), d); check("R3", "bank0 unchanged", d, 32'h1);
    read_reg(sts_ofs(2), d); check("R3", "bank2 unchanged", d, 32'h0);
  endtask

  task automatic t_unmask_fire;
    logic [31:0] d;
    cpu_write(set_ofs(5), 32'h2);
    check("R10", "unmask fires bank5", 32'(irq), 32'h20);
    @(negedge clk);
    check("R7", "line low one clock later", 32'(irq), 0);
    read_reg(set_ofs(5), d); check("R5", "enable via set offset", d, 32'h2);
    read_reg(clr_ofs(5), d); check("R5", "enable via clear offset", d, 32'h2);
  endtask

  task automatic t_ack;
    cpu_write(12'h050, 3);
    check("R8", "reserved code 3 no re-arm", 32'(irq), 0);
    cpu_write(12'h050, 12);
    check("R8", "code 12 no re-arm", 32'(irq), 0);
    cpu_write(12'h050, 4);
    check("R8", "code for bank0 leaves bank5 silent", 32'(irq), 0);
    cpu_write(12'h050, 9);
    check("R8", "code 9 re-fires bank5", 32'(irq), 32'h20);
    @(negedge clk);
    check("R7", "refire is one clock", 32'(irq), 0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    cpu_write(sts_ofs(5), 32'h2);
    read_reg(sts_ofs(5), d); check("R6", "status cleared", d, 0);
    cpu_write(12'h050, 9);
    check("R8", "armed but nothing pending", 32'(irq), 0);
    msi_write(12'h054, 13);
    check("R7", "new vector fires armed bank", 32'(irq), 32'h20);
    @(negedge clk);
    check("R7", "and drops", 32'(irq), 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    cpu_write(sts_ofs(5), 32'h2);
    cpu_write(12'h050, 9);
    cpu_write(clr_ofs(5), 32'h2);
    read_reg(set_ofs(5), d); check("R5", "enable cleared", d, 0);
    msi_write(12'h054, 13);
    check("R4", "masked after clear stays quiet", 32'(irq), 0);
    read_reg(sts_ofs(5), d); check("R4", "still latched", d, 32'h2);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    both_write(31, sts_ofs(7), 32'h8);
    read_reg(sts_ofs(7), d); check("R9", "same-bit set wins", d, 32'h8);
    both_write(23, sts_ofs(7), 32'h8);
    read_reg(sts_ofs(7), d); check("R9", "other bit set, clear applies", d, 32'h4);
    cpu_write(sts_ofs(7), 32'h4);
    read_reg(sts_ofs(7), d); check("R6", "clear alone", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_latch();
    t_ignored();
    t_unmask_fire();
    t_ack();
    t_clear();
    t_mask();
    t_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule